// File: doc/BRIEF.md
# Descriptor DMA Access Sequencer

This block issues the bus-master beats that move one buffer descriptor between system memory and a network controller. A requester gives it a descriptor base address, a layout select (16-bit or 32-bit descriptor format) and one of three jobs. A fetch reads the descriptor. An intermediate writeback stores status for a buffer in the middle of a chain. A final writeback closes a single-buffer descriptor or the last buffer of a chain and hands the buffer back to the host. For every DWORD beat the block drives the address, the byte lane enables and, on writes, the data. It drives these onto a plain request/acknowledge memory port.

The DWORD offsets visited, and their order, depend on the layout and on the direction of the job. The DWORD that holds the ownership flag (bit 31) is always the first one read and the last one written. On a fetch the block checks that flag. It commits the two fetched DWORDs to its capture registers only when the controller owns the descriptor. Otherwise it flags the descriptor as not owned and leaves the captured copy as it was.

Top module: `desc_dma_seq`

## Requirements
- R1: `req_kind` encodes 0 = fetch, 1 = intermediate writeback, 2 = final writeback; code 3 is never accepted. A request is taken on a clock edge where `req_valid` is high and `busy` is low, and `busy` rises in the next cycle. Request inputs seen while `busy` is high have no effect on the beats, the captured fields or the sequence.
- R2: A fetch performs exactly two read beats and no more. All beats of one job share one direction (`mem_we` constant).
- R3: An intermediate writeback performs exactly one write beat: `st_data` with byte enables `st_be`, at the first write offset of the selected layout.
- R4: A final writeback performs two write beats. The first is `st_data` with `st_be`. The second is `own_data` with bit 31 forced to 0 (buffer returned to the host), with byte enables `own_be` OR 4'b1000.
- R5: Each beat address is base bits 31..8 unchanged, followed by base bits 7..2 with two zero bits, plus the beat offset (8-bit wrap). Address bits 1..0 are always 0 and bits 31..8 stay constant through a job.
- R6: With `mode32`=1, reads visit offsets 0x4 then 0x0 and writes visit 0x8 then 0x4. With `mode32`=0, reads visit 0x0 then 0x4 and writes visit 0x4 then 0x0.
- R7: Read beats enable all four lanes (`mem_be`=4'hF). Write beats enable only the lanes given. `mem_be` bit i covers data bits 8i+7..8i.
- R8: On a fetch whose first DWORD has bit 31 = 1, the first DWORD is loaded into `cap_own_dw` and the second into `cap_aux_dw` on the edge that raises `done`.
- R9: On a fetch whose first DWORD has bit 31 = 0, `not_owned` is high in the `done` cycle and both capture registers keep their previous values. `not_owned` is never high outside a `done` cycle.
- R10: A beat holds `mem_addr`, `mem_be`, `mem_wdata` and `mem_we` stable with `mem_req` high until a clock edge where `mem_ack` is high. The next beat starts in the following cycle. `done` is a one-cycle pulse in the cycle after the last acknowledged beat, with `busy` already low.
- R11: After reset `mem_req`, `busy`, `done` and `not_owned` are 0 and both capture registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Job request strobe |
| req_kind | input | 2 | Job code: 0 fetch, 1 intermediate writeback, 2 final writeback |
| mode32 | input | 1 | 1 selects the 32-bit descriptor layout, 0 the 16-bit layout |
| base_addr | input | 32 | Descriptor base address (bits 1..0 ignored) |
| st_data | input | 32 | Status DWORD for the first write beat |
| st_be | input | 4 | Lane enables for the status DWORD |
| own_data | input | 32 | Ownership DWORD contents (bit 31 replaced by 0) |
| own_be | input | 4 | Lane enables for the ownership DWORD (lane 3 always added) |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle completion pulse |
| not_owned | output | 1 | With `done`: fetched descriptor belongs to the host |
| cap_own_dw | output | 32 | Captured DWORD holding the ownership flag |
| cap_aux_dw | output | 32 | Captured second DWORD of the descriptor |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Beat byte address |
| mem_be | output | 4 | Beat lane enables, active high |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory accepts the current beat on this edge |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` on reads |

## Verification
The bench runs each job in both layouts against a memory model with zero and non-zero acknowledge delays. A design with a swapped offset table or a reversed beat order would hit the wrong DWORD and fail the per-beat comparison. A final writeback is followed by a re-fetch of the same descriptor, which must come back as not owned with the old capture intact. A design that left the ownership bit set, or that committed fields without checking it, shows up there. The bench also toggles requests and changes the write data in the middle of a job, and sends the unused job code. A design that re-latched inputs while busy or started an extra beat would produce an unexpected beat or wrong data. A base address with its low bits set is used to catch an address path that leaks those bits.

// File: rtl/desc_dma_pkg.sv
package desc_dma_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_CHAIN = 2'd1,
    KIND_FINAL = 2'd2,
    KIND_NONE  = 2'd3
  } desc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } seq_state_e;

  localparam int OFF_W = 4;

  // Byte offset of a beat inside the descriptor, by layout, direction and beat.
  function automatic logic [OFF_W-1:0] beat_offset(input logic wide,
                                                   input logic wr,
                                                   input logic second);
    logic [OFF_W-1:0] off;
    unique case ({wide, wr, second})
      3'b000:  off = 4'h0;
      3'b001:  off = 4'h4;
      3'b010:  off = 4'h4;
      3'b011:  off = 4'h0;
      3'b100:  off = 4'h4;
      3'b101:  off = 4'h0;
      3'b110:  off = 4'h8;
      default: off = 4'h4;
    endcase
    return off;
  endfunction

  function automatic logic kind_valid(input logic [1:0] k);
    return k != KIND_NONE;
  endfunction

endpackage

// File: rtl/desc_dma_ctl.sv
module desc_dma_ctl
  import desc_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_kind,
  input  logic       mem_ack,
  output logic       busy,
  output logic       beat_second,
  output logic       is_write,
  output logic       accept,
  output logic       beat_fire,
  output logic       last_fire,
  output logic       done
);

  seq_state_e state_q, state_d;
  desc_kind_e kind_q;

  assign busy        = (state_q != ST_IDLE);
  assign accept      = !busy && req_valid && kind_valid(req_kind);
  assign beat_second = (state_q == ST_SECOND);
  assign is_write    = (kind_q != KIND_FETCH);
  assign beat_fire   = busy && mem_ack;
  assign last_fire   = beat_fire && (beat_second || kind_q == KIND_CHAIN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = ST_FIRST;
      ST_FIRST:  if (beat_fire) state_d = last_fire ? ST_IDLE : ST_SECOND;
      ST_SECOND: if (beat_fire) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= KIND_FETCH;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= last_fire;
      if (accept) kind_q <= desc_kind_e'(req_kind);
    end
  end

endmodule

// File: rtl/desc_dma_dp.sv
module desc_dma_dp
  import desc_dma_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int PAGE_LSB = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic                busy,
  input  logic                is_write,
  input  logic                beat_second,
  input  logic                mode32,
  input  logic [ADDR_W-1:0]   base_addr,
  input  logic [DATA_W-1:0]   st_data,
  input  logic [DATA_W/8-1:0] st_be,
  input  logic [DATA_W-1:0]   own_data,
  input  logic [DATA_W/8-1:0] own_be,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0]   mem_wdata
);

  localparam int BE_W = DATA_W / 8;
  localparam logic [BE_W-1:0] OWN_LANE = BE_W'(1) << (BE_W - 1);

  logic [ADDR_W-1:0] base_q;
  logic              wide_q;
  logic [DATA_W-1:0] st_q, own_q;
  logic [BE_W-1:0]   st_be_q, own_be_q;
  logic [OFF_W-1:0]  off;

  // Upper page bits pass through; offset added inside the page only.
  function automatic logic [ADDR_W-1:0] page_addr(input logic [ADDR_W-1:0] b,
                                                  input logic [OFF_W-1:0] o);
    logic [PAGE_LSB-1:0] low;
    low = {b[PAGE_LSB-1:2], 2'b00} + PAGE_LSB'(o);
    return {b[ADDR_W-1:PAGE_LSB], low};
  endfunction

  function automatic logic [DATA_W-1:0] give_back(input logic [DATA_W-1:0] d);
    return {1'b0, d[DATA_W-2:0]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      wide_q   <= 1'b0;
      st_q     <= '0;
      own_q    <= '0;
      st_be_q  <= '0;
      own_be_q <= '0;
    end else if (accept) begin
      base_q   <= base_addr;
      wide_q   <= mode32;
      st_q     <= st_data;
      own_q    <= own_data;
      st_be_q  <= st_be;
      own_be_q <= own_be;
    end
  end

  assign off      = beat_offset(wide_q, is_write, beat_second);
  assign mem_req  = busy;
  assign mem_we   = busy && is_write;
  assign mem_addr = page_addr(base_q, off);

  always_comb begin
    if (!is_write) begin
      mem_be    = '1;
      mem_wdata = '0;
    end else if (beat_second) begin
      mem_be    = own_be_q | OWN_LANE;
      mem_wdata = give_back(own_q);
    end else begin
      mem_be    = st_be_q;
      mem_wdata = st_q;
    end
  end

endmodule

// File: rtl/desc_dma_cap.sv
module desc_dma_cap #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_fire,
  input  logic              last_fire,
  input  logic              beat_second,
  input  logic              is_write,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] cap_own_dw,
  output logic [DATA_W-1:0] cap_aux_dw,
  output logic              not_owned
);

  localparam int OWN_BIT = DATA_W - 1;

  logic [DATA_W-1:0] stage_q;
  logic              first_rd, final_rd;

  assign first_rd = beat_fire && !is_write && !beat_second;
  assign final_rd = last_fire && !is_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q    <= '0;
      cap_own_dw <= '0;
      cap_aux_dw <= '0;
      not_owned  <= 1'b0;
    end else begin
      not_owned <= final_rd && !stage_q[OWN_BIT];
      if (first_rd) stage_q <= mem_rdata;
      if (final_rd && stage_q[OWN_BIT]) begin
        cap_own_dw <= stage_q;
        cap_aux_dw <= mem_rdata;
      end
    end
  end

endmodule

// File: rtl/desc_dma_seq.sv
module desc_dma_seq #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int PAGE_LSB = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [1:0]          req_kind,
  input  logic                mode32,
  input  logic [ADDR_W-1:0]   base_addr,
  input  logic [DATA_W-1:0]   st_data,
  input  logic [DATA_W/8-1:0] st_be,
  input  logic [DATA_W-1:0]   own_data,
  input  logic [DATA_W/8-1:0] own_be,
  output logic                busy,
  output logic                done,
  output logic                not_owned,
  output logic [DATA_W-1:0]   cap_own_dw,
  output logic [DATA_W-1:0]   cap_aux_dw,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic                mem_ack,
  input  logic [DATA_W-1:0]   mem_rdata
);

  // Internal events, named for the checker.
  logic accept, beat_fire, last_fire, beat_second, is_write;

  desc_dma_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .mem_ack     (mem_ack),
    .busy        (busy),
    .beat_second (beat_second),
    .is_write    (is_write),
    .accept      (accept),
    .beat_fire   (beat_fire),
    .last_fire   (last_fire),
    .done        (done)
  );

  desc_dma_dp #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PAGE_LSB (PAGE_LSB)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .busy        (busy),
    .is_write    (is_write),
    .beat_second (beat_second),
    .mode32      (mode32),
    .base_addr   (base_addr),
    .st_data     (st_data),
    .st_be       (st_be),
    .own_data    (own_data),
    .own_be      (own_be),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_be      (mem_be),
    .mem_wdata   (mem_wdata)
  );

  desc_dma_cap #(
    .DATA_W (DATA_W)
  ) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .beat_fire   (beat_fire),
    .last_fire   (last_fire),
    .beat_second (beat_second),
    .is_write    (is_write),
    .mem_rdata   (mem_rdata),
    .cap_own_dw  (cap_own_dw),
    .cap_aux_dw  (cap_aux_dw),
    .not_owned   (not_owned)
  );

endmodule

// File: rtl/desc_dma_seq_chk.sv
module desc_dma_seq_chk #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int PAGE_LSB = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [1:0]          req_kind,
  input logic                busy,
  input logic                done,
  input logic                not_owned,
  input logic                mem_req,
  input logic                mem_ack,
  input logic                mem_we,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic [DATA_W/8-1:0] mem_be,
  input logic [DATA_W-1:0]   mem_wdata,
  input logic                beat_second,
  input logic                accept,
  input logic                beat_fire
);

  localparam int BE_W = DATA_W / 8;

  logic [1:0] beats_seen;

  always_ff @(posedge clk) begin
    if (!rst_n)         beats_seen <= '0;
    else if (accept)    beats_seen <= '0;
    else if (beat_fire) beats_seen <= beats_seen + 2'd1;
  end

  a_r10_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_be)
                            && $stable(mem_wdata) && $stable(mem_we));

  a_r5_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  a_r5_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && $past(mem_req) |-> mem_addr[ADDR_W-1:PAGE_LSB] == $past(mem_addr[ADDR_W-1:PAGE_LSB]));

  a_r2_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && $past(mem_req) |-> mem_we == $past(mem_we));

  a_r2_at_most_two: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire |-> beats_seen < 2'd2);

  a_r7_reads_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> &mem_be);

  a_r4_own_returned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && beat_second |-> mem_be[BE_W-1] && !mem_wdata[DATA_W-1]);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r9_flag_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    not_owned |-> done);

  a_r1_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && req_valid && req_kind != 2'd3 |=> busy);

  a_r1_code3_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && req_valid && req_kind == 2'd3 |=> !busy);

endmodule

bind desc_dma_seq desc_dma_seq_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .PAGE_LSB (PAGE_LSB)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_kind    (req_kind),
  .busy        (busy),
  .done        (done),
  .not_owned   (not_owned),
  .mem_req     (mem_req),
  .mem_ack     (mem_ack),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_be      (mem_be),
  .mem_wdata   (mem_wdata),
  .beat_second (beat_second),
  .accept      (accept),
  .beat_fire   (beat_fire)
);

// File: tb/desc_dma_seq_test.sv
`timescale 1ns/1ps
module desc_dma_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic        mode32 = 1'b0;
  logic [31:0] base_addr = '0;
  logic [31:0] st_data = '0;
  logic [3:0]  st_be = '0;
  logic [31:0] own_data = '0;
  logic [3:0]  own_be = '0;
  logic        busy, done, not_owned;
  logic [31:0] cap_own_dw, cap_aux_dw;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  desc_dma_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .mode32(mode32), .base_addr(base_addr), .st_data(st_data), .st_be(st_be),
    .own_data(own_data), .own_be(own_be), .busy(busy), .done(done),
    .not_owned(not_owned), .cap_own_dw(cap_own_dw), .cap_aux_dw(cap_aux_dw),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int errors = 0;

  logic [31:0] model [0:63];

  // Scoreboard queues of expected beats.
  logic [31:0] q_addr [$];
  logic        q_we   [$];
  logic [3:0]  q_be   [$];
  logic [31:0] q_wd   [$];
  string       q_tag  [$];

  int          ack_delay = 0;
  logic [31:0] exp_own = '0, exp_aux = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_off(input logic m32, input logic wr, input logic beat);
    if (m32) return wr ? (beat ? 4'h4 : 4'h8) : (beat ? 4'h0 : 4'h4);
    return (wr ^ beat) ? 4'h4 : 4'h0;
  endfunction

  function automatic logic [31:0] beat_adr(input logic [31:0] b, input logic m32,
                                           input logic wr, input logic beat);
    return (b & 32'hFFFF_FFFC) + {28'd0, exp_off(m32, wr, beat)};
  endfunction

  // Memory responder and monitor.
  int          wait_cnt = 0;
  bit          held = 0;
  logic [31:0] h_addr, h_wd;
  logic [3:0]  h_be;
  logic        h_we;

  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      if (held) begin
        chk(mem_addr == h_addr && mem_be == h_be && mem_wdata == h_wd && mem_we == h_we,
            "R10 beat held until ack", mem_addr, h_addr);
      end
      if (wait_cnt >= ack_delay) begin
        if (q_addr.size() == 0) begin
          chk(1'b0, "R1 R2 R3 unexpected beat", mem_addr, 32'h0);
        end else begin
          logic [31:0] ea, ew; logic eq_we; logic [3:0] eb; string t;
          ea = q_addr.pop_front(); eq_we = q_we.pop_front();
          eb = q_be.pop_front(); ew = q_wd.pop_front(); t = q_tag.pop_front();
          chk(mem_addr == ea, {t, " addr"}, mem_addr, ea);
          chk(mem_we == eq_we, {t, " dir"}, {31'd0, mem_we}, {31'd0, eq_we});
          chk(mem_be == eb, {t, " lanes"}, {28'd0, mem_be}, {28'd0, eb});
          if (eq_we) chk(mem_wdata == ew, {t, " data"}, mem_wdata, ew);
        end
        if (mem_we) begin
          for (int i = 0; i < 4; i++)
            if (mem_be[i]) model[mem_addr[7:2]][8*i +: 8] = mem_wdata[8*i +: 8];
          mem_rdata = 32'hDEAD_BEEF;
        end else begin
          mem_rdata = model[mem_addr[7:2]];
        end
        mem_ack  = 1'b1;
        wait_cnt = 0;
        held     = 0;
      end else begin
        wait_cnt++;
        mem_ack   = 1'b0;
        mem_rdata = 32'hDEAD_BEEF;
        held = 1; h_addr = mem_addr; h_be = mem_be; h_wd = mem_wdata; h_we = mem_we;
      end
    end else begin
      mem_ack = 1'b0;
      held = 0;
      wait_cnt = 0;
    end
  end

  task automatic push(input logic [31:0] a, input logic we, input logic [3:0] be,
                      input logic [31:0] wd, input string t);
    q_addr.push_back(a); q_we.push_back(we); q_be.push_back(be);
    q_wd.push_back(wd); q_tag.push_back(t);
  endtask

  // Driver: push expected beats, issue the job, check completion.
  task automatic do_req(input logic [1:0] kind, input logic m32, input logic [31:0] base,
                        input logic [31:0] sd, input logic [3:0] sb,
                        input logic [31:0] od, input logic [3:0] ob, input bit meddle);
    logic exp_no;
    exp_no = 1'b0;
    if (kind == 2'd0) begin
      logic [31:0] a0, a1, v0, v1;
      a0 = beat_adr(base, m32, 1'b0, 1'b0);
      a1 = beat_adr(base, m32, 1'b0, 1'b1);
      v0 = model[a0[7:2]]; v1 = model[a1[7:2]];
      push(a0, 1'b0, 4'hF, 32'h0, "R2 R5 R6 R7 fetch beat0");
      push(a1, 1'b0, 4'hF, 32'h0, "R2 R5 R6 R7 fetch beat1");
      if (v0[31]) begin exp_own = v0; exp_aux = v1; end
      else exp_no = 1'b1;
    end else begin
      push(beat_adr(base, m32, 1'b1, 1'b0), 1'b1, sb, sd, "R3 R5 R6 R7 status write");
      if (kind == 2'd2)
        push(beat_adr(base, m32, 1'b1, 1'b1), 1'b1, ob | 4'b1000, {1'b0, od[30:0]},
             "R4 R5 R6 ownership write");
    end
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; mode32 = m32; base_addr = base;
    st_data = sd; st_be = sb; own_data = od; own_be = ob;
    @(negedge clk);
    chk(busy === 1'b1, "R1 busy after accept", {31'd0, busy}, 32'd1);
    if (meddle) begin
      req_kind = (kind == 2'd0) ? 2'd2 : 2'd0; mode32 = ~m32; base_addr = base ^ 32'h0F00_0030;
      st_data = ~sd; st_be = ~sb; own_data = ~od; own_be = ~ob;
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (done !== 1'b1) @(negedge clk);
    chk(busy === 1'b0, "R10 idle with done", {31'd0, busy}, 32'd0);
    chk(not_owned === exp_no, "R9 not_owned flag", {31'd0, not_owned}, {31'd0, exp_no});
    chk(cap_own_dw === exp_own, "R8 R9 cap_own_dw", cap_own_dw, exp_own);
    chk(cap_aux_dw === exp_aux, "R8 R9 cap_aux_dw", cap_aux_dw, exp_aux);
    chk(q_addr.size() == 0, "R2 R3 R4 beats all seen", q_addr.size(), 0);
    @(negedge clk);
    chk(done === 1'b0 && mem_req === 1'b0, "R10 done one cycle, no extra beat",
        {30'd0, done, mem_req}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 32'h1000_0000 + i;
    model[6'h11] = 32'h8123_4567;   // 0x44: owned
    model[6'h10] = 32'h0BAD_CAFE;   // 0x40
    model[6'h20] = 32'h8000_AA55;   // 0x80: owned (16-bit layout)
    model[6'h21] = 32'h1234_5678;   // 0x84
    model[6'h30] = 32'h8765_4321;   // 0xC0: owned
    model[6'h31] = 32'h0000_C0DE;   // 0xC4

    repeat (3) @(negedge clk);
    // R11 reset state
    chk(mem_req === 1'b0 && busy === 1'b0 && done === 1'b0 && not_owned === 1'b0,
        "R11 reset outputs", {28'd0, mem_req, busy, done, not_owned}, 32'd0);
    chk(cap_own_dw === 32'd0 && cap_aux_dw === 32'd0, "R11 reset captures", cap_own_dw, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    ack_delay = 0;
    do_req(2'd0, 1'b1, 32'h1000_0040, 0, 0, 0, 0, 0);
    ack_delay = 2;
    do_req(2'd0, 1'b0, 32'h2000_0080, 0, 0, 0, 0, 0);
    ack_delay = 0;
    do_req(2'd1, 1'b1, 32'h1000_0040, 32'hCAFE_0001, 4'b0011, 32'h0, 4'b0, 1);
    ack_delay = 1;
    do_req(2'd2, 1'b1, 32'h1000_0040, 32'h5555_AAAA, 4'b1111, 32'hFFFF_0000, 4'b0100, 0);
    // Re-fetch: ownership now cleared, captures must stay.
    ack_delay = 0;
    do_req(2'd0, 1'b1, 32'h1000_0040, 0, 0, 0, 0, 1);
    ack_delay = 3;
    do_req(2'd2, 1'b0, 32'h2000_0080, 32'h0000_BEEF, 4'b0001, 32'hC000_1234, 4'b0011, 1);
    ack_delay = 0;
    do_req(2'd1, 1'b0, 32'h2000_0080, 32'hABCD_EF01, 4'b1100, 32'h0, 4'b0, 0);
    ack_delay = 1;
    do_req(2'd0, 1'b0, 32'h3000_00C3, 0, 0, 0, 0, 0);

    // R1: code 3 is never taken.
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd3; mode32 = 1'b1; base_addr = 32'h1000_0040;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(mem_req === 1'b0 && busy === 1'b0, "R1 code 3 ignored",
          {30'd0, mem_req, busy}, 32'd0);
      @(negedge clk);
    end
    chk(cap_own_dw === exp_own, "R1 code 3 leaves captures", cap_own_dw, exp_own);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule